// File: doc/BRIEF.md
# Floating-Point Compare to Status Flags

The block takes two scalar floating-point operands, either binary32 or binary64, and turns their ordering into a six-bit flag word. That word has the layout of an integer-unit condition register. Each compare request arrives as a one-cycle `in_valid` strobe. The result comes out registered one clock later. It consists of the flag word, a write enable for an external flag register, and a single-cycle invalid-operation indication, which an external sticky status register can OR in.

Two compare flavours are supported, chosen by `unord_mode`:

- **Ordered compare** (`unord_mode` = 0): any NaN operand, quiet or signalling, is an invalid operation.
- **Unordered compare** (`unord_mode` = 1): only a signalling NaN is invalid. A quiet NaN simply yields the unordered flag pattern.

When an invalid operation is masked, the flags still receive the unordered pattern. When it is unmasked, the flag write is suppressed, so that an exception path outside this block can take over.

Top module: `fp_cmp_flags`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `flags_o` is 0, `flags_we` is 0 and `inv_o` is 0.
- R2: A request sampled with `in_valid` high at a rising edge drives `flags_we`/`inv_o` for exactly the following cycle. A cycle without a request leaves `flags_we` and `inv_o` low and `flags_o` unchanged.
- R3: `flags_o` bit order is {OF,SF,AF,ZF,PF,CF} (bit 5 down to bit 0). OF, SF and AF are 0 on every write. When operand A is greater than B, the written value is 6'b000000.
- R4: When A is less than B, the written value is 6'b000001 (CF only).
- R5: When A equals B, the written value is 6'b000100 (ZF only). +0 and -0 compare equal.
- R6: Non-NaN ordering follows the sign-magnitude value of the encodings. A negative operand is below a positive one. Among negatives, the larger magnitude is the smaller value. Infinities and subnormals order naturally.
- R7: With `dbl_sel`=0, each operand is the binary32 value in bits [31:0], and bits [63:32] have no effect. With `dbl_sel`=1, all 64 bits form a binary64 value.
- R8: If either operand is a NaN (all-ones exponent, non-zero fraction), any flag write carries the unordered pattern 6'b000111.
- R9: In ordered mode, a quiet or signalling NaN in either operand sets `inv_o`. With `inv_mask`=1, `flags_we` is also set, carrying the unordered pattern.
- R10: An invalid operation with `inv_mask`=0 sets `inv_o` and keeps `flags_we` low. `flags_o` keeps its previous value.
- R11: In unordered mode, a quiet NaN is not invalid when the other operand is not signalling. `inv_o` stays 0, and the unordered pattern is written whatever the value of `inv_mask`.
- R12: In unordered mode, a signalling NaN in either operand (a NaN whose fraction MSB is 0) sets `inv_o`. The write then follows `inv_mask`, as in R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| op_a | input | 64 | Operand A (binary32 uses bits 31:0) |
| op_b | input | 64 | Operand B (binary32 uses bits 31:0) |
| dbl_sel | input | 1 | 1 = binary64, 0 = binary32 |
| unord_mode | input | 1 | 1 = unordered compare, 0 = ordered compare |
| inv_mask | input | 1 | 1 = invalid operation masked |
| flags_o | output | 6 | {OF,SF,AF,ZF,PF,CF}, held between writes |
| flags_we | output | 1 | One-cycle write enable for `flags_o` |
| inv_o | output | 1 | One-cycle invalid-operation indication |

## Verification
All three results are due in the single cycle after the edge that samples `in_valid`, and there is no further pipeline stage. Each scenario task therefore drives a request on a falling edge and withdraws it on the next falling edge. It reads `flags_o`, `flags_we` and `inv_o` at that second falling edge, which sits midway through the only cycle in which the result is presented. Held-value cases are checked the same way: the task first writes a known flag word, and only then issues the request that must suppress the write.

// File: rtl/fpcf_pkg.sv
package fpcf_pkg;
  parameter int SGL_EXP_W = 8;
  parameter int SGL_FRC_W = 23;
  parameter int DBL_EXP_W = 11;
  parameter int DBL_FRC_W = 52;
  localparam int WORD_W   = 1 + DBL_EXP_W + DBL_FRC_W;
  localparam int MAG_W    = WORD_W - 1;
  localparam int FLAG_W   = 6;

  // flag positions inside the six-bit word
  localparam int FB_CF = 0;
  localparam int FB_PF = 1;
  localparam int FB_ZF = 2;
  localparam int FB_AF = 3;
  localparam int FB_SF = 4;
  localparam int FB_OF = 5;

  typedef struct packed {
    logic             sign;
    logic             is_zero;
    logic             is_nan;
    logic             is_snan;
    logic [MAG_W-1:0] mag;
  } opnd_info_t;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2
  } rel_t;

  localparam logic [FLAG_W-1:0] FLAGS_GT = 6'b000000;
  localparam logic [FLAG_W-1:0] FLAGS_LT = 6'b000001;
  localparam logic [FLAG_W-1:0] FLAGS_EQ = 6'b000100;
  localparam logic [FLAG_W-1:0] FLAGS_UN = 6'b000111;
endpackage

// File: rtl/fpcf_classify.sv
module fpcf_classify
  import fpcf_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRC_W = 23,
  localparam int W    = 1 + EXP_W + FRC_W
) (
  input  logic [W-1:0] word,
  output opnd_info_t   info
);
  logic [EXP_W-1:0] expo;
  logic [FRC_W-1:0] frac;
  logic             exp_ones;
  logic             frac_nz;

  assign expo     = word[W-2 -: EXP_W];
  assign frac     = word[FRC_W-1:0];
  assign exp_ones = &expo;
  assign frac_nz  = |frac;

  always_comb begin
    info.sign    = word[W-1];
    info.mag     = MAG_W'(word[W-2:0]);
    info.is_zero = ~|word[W-2:0];
    info.is_nan  = exp_ones & frac_nz;
    info.is_snan = exp_ones & frac_nz & ~frac[FRC_W-1];
  end
endmodule

// File: rtl/fpcf_order.sv
module fpcf_order
  import fpcf_pkg::*;
(
  input  opnd_info_t a,
  input  opnd_info_t b,
  output rel_t       rel
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = a.mag < b.mag;
  assign mag_eq = a.mag == b.mag;

  always_comb begin
    if (a.is_zero && b.is_zero) begin
      rel = REL_EQ;
    end else if (a.sign != b.sign) begin
      rel = a.sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (a.sign) begin
      rel = mag_lt ? REL_GT : REL_LT;
    end else begin
      rel = mag_lt ? REL_LT : REL_GT;
    end
  end
endmodule

// File: rtl/fpcf_decide.sv
module fpcf_decide
  import fpcf_pkg::*;
(
  input  opnd_info_t        a,
  input  opnd_info_t        b,
  input  rel_t              rel,
  input  logic              unord_mode,
  input  logic              inv_mask,
  output logic [FLAG_W-1:0] flags_nx,
  output logic              we_nx,
  output logic              inv_nx
);
  logic any_nan;
  logic any_snan;

  assign any_nan  = a.is_nan | b.is_nan;
  assign any_snan = a.is_snan | b.is_snan;

  always_comb begin
    inv_nx = any_nan & (~unord_mode | any_snan);
    we_nx  = ~inv_nx | inv_mask;
    if (any_nan) begin
      flags_nx = FLAGS_UN;
    end else begin
      unique case (rel)
        REL_LT:  flags_nx = FLAGS_LT;
        REL_EQ:  flags_nx = FLAGS_EQ;
        default: flags_nx = FLAGS_GT;
      endcase
    end
  end
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fpcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              dbl_sel,
  input  logic              unord_mode,
  input  logic              inv_mask,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flags_we,
  output logic              inv_o
);
  localparam int N_FMT = 2;

  opnd_info_t info_a [N_FMT];
  opnd_info_t info_b [N_FMT];
  opnd_info_t sel_a;
  opnd_info_t sel_b;
  rel_t       rel;
  logic [FLAG_W-1:0] flags_nx;
  logic              we_nx;
  logic              inv_nx;

  for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
    localparam int EW = (f == 0) ? SGL_EXP_W : DBL_EXP_W;
    localparam int FW = (f == 0) ? SGL_FRC_W : DBL_FRC_W;
    localparam int TW = 1 + EW + FW;
    fpcf_classify #(.EXP_W(EW), .FRC_W(FW)) i_cls_a (
      .word (op_a[TW-1:0]),
      .info (info_a[f])
    );
    fpcf_classify #(.EXP_W(EW), .FRC_W(FW)) i_cls_b (
      .word (op_b[TW-1:0]),
      .info (info_b[f])
    );
  end

  assign sel_a = dbl_sel ? info_a[1] : info_a[0];
  assign sel_b = dbl_sel ? info_b[1] : info_b[0];

  fpcf_order i_order (
    .a   (sel_a),
    .b   (sel_b),
    .rel (rel)
  );

  fpcf_decide i_decide (
    .a          (sel_a),
    .b          (sel_b),
    .rel        (rel),
    .unord_mode (unord_mode),
    .inv_mask   (inv_mask),
    .flags_nx   (flags_nx),
    .we_nx      (we_nx),
    .inv_nx     (inv_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o  <= '0;
      flags_we <= 1'b0;
      inv_o    <= 1'b0;
    end else begin
      flags_we <= in_valid & we_nx;
      inv_o    <= in_valid & inv_nx;
      if (in_valid && we_nx) flags_o <= flags_nx;
    end
  end
endmodule

// File: rtl/fpcf_checker.sv
module fpcf_checker
  import fpcf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              inv_mask,
  input logic [FLAG_W-1:0] flags_o,
  input logic              flags_we,
  input logic              inv_o
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!flags_we && !inv_o));

  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
    !flags_we |-> $stable(flags_o));

  p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_o[FB_OF] == 1'b0 && flags_o[FB_SF] == 1'b0 && flags_o[FB_AF] == 1'b0));

  p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_o == FLAGS_GT || flags_o == FLAGS_LT ||
                  flags_o == FLAGS_EQ || flags_o == FLAGS_UN));

  p_masked_writes_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inv_mask) |=> flags_we);

  p_unmasked_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inv_mask) |=> !(flags_we && inv_o));

  p_inv_write_unordered_r12: assert property (@(posedge clk) disable iff (rst)
    (inv_o && flags_we) |-> (flags_o == FLAGS_UN));
endmodule

bind fp_cmp_flags fpcf_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .inv_mask (inv_mask),
  .flags_o  (flags_o),
  .flags_we (flags_we),
  .inv_o    (inv_o)
);

// File: tb/test_fp_cmp_flags.sv
`timescale 1ns/1ps
module test_fp_cmp_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dbl_sel = 1'b0;
  logic        unord_mode = 1'b0;
  logic        inv_mask = 1'b1;
  logic [5:0]  flags_o;
  logic        flags_we;
  logic        inv_o;

  int total = 0;
  int bad   = 0;

  localparam logic [5:0] GT = 6'b000000;
  localparam logic [5:0] LT = 6'b000001;
  localparam logic [5:0] EQ = 6'b000100;
  localparam logic [5:0] UN = 6'b000111;

  localparam logic [31:0] S_P1   = 32'h3F80_0000;
  localparam logic [31:0] S_P2   = 32'h4000_0000;
  localparam logic [31:0] S_M1   = 32'hBF80_0000;
  localparam logic [31:0] S_M2   = 32'hC000_0000;
  localparam logic [31:0] S_PZ   = 32'h0000_0000;
  localparam logic [31:0] S_MZ   = 32'h8000_0000;
  localparam logic [31:0] S_PINF = 32'h7F80_0000;
  localparam logic [31:0] S_MINF = 32'hFF80_0000;
  localparam logic [31:0] S_DEN  = 32'h0000_0001;
  localparam logic [31:0] S_QN   = 32'h7FC0_0000;
  localparam logic [31:0] S_SN   = 32'h7F80_0001;
  localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_MZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_QN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SN   = 64'h7FF0_0000_0000_0001;

  fp_cmp_flags i_fp_cmp_flags (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .dbl_sel    (dbl_sel),
    .unord_mode (unord_mode),
    .inv_mask   (inv_mask),
    .flags_o    (flags_o),
    .flags_we   (flags_we),
    .inv_o      (inv_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [5:0] ef, input logic ew, input logic ei);
    total++;
    if (flags_o !== ef || flags_we !== ew || inv_o !== ei) begin
      bad++;
      $display("FAIL %s: flags=%b we=%b inv=%b expected flags=%b we=%b inv=%b",
               req, flags_o, flags_we, inv_o, ef, ew, ei);
    end
  endtask

  // one request; outputs are read in the cycle after the sampling edge
  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                       input logic unord, input logic mask);
    @(negedge clk);
    op_a = a; op_b = b; dbl_sel = dbl; unord_mode = unord; inv_mask = mask;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 during reset", 6'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 6'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ordered_single;
    issue({32'h0, S_P2}, {32'h0, S_P1}, 0, 0, 1); check("R3 2>1", GT, 1, 0);
    issue({32'h0, S_P1}, {32'h0, S_P2}, 0, 0, 1); check("R4 1<2", LT, 1, 0);
    issue({32'h0, S_P1}, {32'h0, S_P1}, 0, 1, 0); check("R5 1==1", EQ, 1, 0);
    issue({32'h0, S_PZ}, {32'h0, S_MZ}, 0, 0, 1); check("R5 +0==-0", EQ, 1, 0);
  endtask

  task automatic t_sign_mag;
    issue({32'h0, S_M1}, {32'h0, S_P1}, 0, 0, 1);   check("R6 -1<1", LT, 1, 0);
    issue({32'h0, S_M2}, {32'h0, S_M1}, 0, 0, 1);   check("R6 -2<-1", LT, 1, 0);
    issue({32'h0, S_M1}, {32'h0, S_M2}, 0, 0, 1);   check("R6 -1>-2", GT, 1, 0);
    issue({32'h0, S_PINF}, {32'h0, S_P2}, 0, 0, 1); check("R6 inf>2", GT, 1, 0);
    issue({32'h0, S_MINF}, {32'h0, S_M2}, 0, 0, 1); check("R6 -inf<-2", LT, 1, 0);
    issue({32'h0, S_DEN}, {32'h0, S_MZ}, 0, 0, 1);  check("R6 den>-0", GT, 1, 0);
    issue({32'h0, S_MZ}, {32'h0, S_DEN}, 0, 0, 1);  check("R6 -0<den", LT, 1, 0);
  endtask

  task automatic t_precision;
    issue({32'hDEAD_BEEF, S_P1}, {32'h1234_5678, S_P2}, 0, 0, 1); check("R7 upper ignored", LT, 1, 0);
    issue({32'h7FF8_0000, S_P1}, {32'h0, S_P1}, 0, 0, 0);          check("R7 upper nan ignored", EQ, 1, 0);
    issue(D_P2, D_P1, 1, 0, 1);  check("R7 dbl 2>1", GT, 1, 0);
    issue(64'h0, D_MZ, 1, 0, 1); check("R7 dbl +0==-0", EQ, 1, 0);
    issue(D_P1, D_P2, 1, 0, 1);  check("R7 dbl 1<2", LT, 1, 0);
  endtask

  task automatic t_ordered_nan;
    issue({32'h0, S_QN}, {32'h0, S_P1}, 0, 0, 1); check("R9 ord qnan masked", UN, 1, 1);
    issue({32'h0, S_P1}, {32'h0, S_SN}, 0, 0, 1); check("R9 ord snan b masked", UN, 1, 1);
    issue(D_P1, D_QN, 1, 0, 1);                   check("R8 dbl qnan", UN, 1, 1);
    issue({32'h0, S_P1}, {32'h0, S_P2}, 0, 0, 1); check("R10 prime", LT, 1, 0);
    issue({32'h0, S_P1}, {32'h0, S_QN}, 0, 0, 0); check("R10 ord qnan unmasked", LT, 0, 1);
    @(negedge clk);                               check("R2 idle after", LT, 0, 0);
  endtask

  task automatic t_unordered_nan;
    issue({32'h0, S_QN}, {32'h0, S_P1}, 0, 1, 1); check("R11 qnan masked", UN, 1, 0);
    issue({32'h0, S_P2}, {32'h0, S_P1}, 0, 1, 1); check("R11 prime", GT, 1, 0);
    issue({32'h0, S_P1}, {32'h0, S_QN}, 0, 1, 0); check("R11 qnan unmasked", UN, 1, 0);
    issue(D_QN, D_QN, 1, 1, 0);                   check("R11 dbl qnan both", UN, 1, 0);
    issue({32'h0, S_SN}, {32'h0, S_P1}, 0, 1, 1); check("R12 snan masked", UN, 1, 1);
    issue({32'h0, S_QN}, {32'h0, S_SN}, 0, 1, 1); check("R12 qnan+snan", UN, 1, 1);
    issue({32'h0, S_M1}, {32'h0, S_P1}, 0, 1, 1); check("R12 prime", LT, 1, 0);
    issue(D_P1, D_SN, 1, 1, 0);                   check("R12 dbl snan unmasked", LT, 0, 1);
  endtask

  task automatic t_idle;
    issue({32'h0, S_P2}, {32'h0, S_P1}, 0, 0, 1); check("R2 write", GT, 1, 0);
    op_a = {32'h0, S_P1}; op_b = {32'h0, S_P2};
    repeat (3) @(negedge clk);
    check("R2 no request", GT, 0, 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ordered_single();
    t_sign_mag();
    t_precision();
    t_ordered_nan();
    t_unordered_nan();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule